// File: doc/BRIEF.md
# DMA Channel Launch Control

This block holds the per-channel control, address and block-count registers of a seven-channel DMA engine, plus one shared configuration word that has a four-bit field for each channel. From a stream of single-cycle register writes it decides when a channel transfer must begin and when one must be cancelled. It reports each decision as a one-cycle pulse in a per-channel vector. In the same cycle, the channel's stored address, count and control words are on the outputs, ready for the transfer engine downstream.

A launch happens on the rising edge of a channel's busy bit (bit 24 of its control word), provided the channel's enable bit in the shared word is set. Setting that enable bit later also launches a channel whose busy bit is already set. Clearing the busy bit always produces a cancel pulse. Each channel filters its control writes through its own write mask. The last channel has a narrower mask and one bit held permanently at 1. Channel 5 has no hardware.

Top module: `dma_launch_ctrl`

## Requirements
- R1: After reset every register reads zero, except the channel-6 control word, which reads 0x00000002. Both pulse vectors are zero.
- R2: A write to byte offset 0x8 or 0xC of channel n's window (base 0x080 + 16*n) stores the written data ANDed with 0x71770703 into the control word of channels 0 to 4.
- R3: Control writes to channel 6 (offsets 0xE8/0xEC) store the data ANDed with 0x51000002, with bit 1 then forced to 1.
- R4: A control write that changes bit 24 from 0 to 1 raises start_vec[n] in the cycle after the write edge, only if shared bit 4*n+3 is set. Otherwise no start occurs.
- R5: A control write that changes bit 24 from 1 to 0 raises abort_vec[n] in the cycle after the write edge, whatever the enable bit holds.
- R6: A control write whose masked value equals the stored word changes nothing and produces no pulse.
- R7: A write to offset 0x0F0 stores all 32 bits into the shared word. Every channel whose bit 4*n+3 goes from 0 to 1 while its bit 24 is set receives a start pulse, and several channels can pulse together in one vector.
- R8: Writes to offset 0x0 and 0x4 of a channel window store the full 32-bit address and block count. These are presented on chan_madr and chan_cnt.
- R9: Channel 5 (window 0x0D0) ignores every write, reads zero and never pulses.
- R10: Each pulse lasts exactly one cycle. Writes to offsets outside the channel windows and the shared word leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| start_vec | output | 7 | One-cycle launch pulse per channel |
| abort_vec | output | 7 | One-cycle cancel pulse per channel |
| chan_madr | output | 224 | Address word of each channel, channel n at bits 32n+31:32n |
| chan_cnt | output | 224 | Block-count word of each channel |
| chan_ctrl | output | 224 | Control word of each channel |
| prio_cfg | output | 32 | Shared priority/enable word |

## Verification
The bench sweeps every channel window with all-ones, all-zeros and a lone busy bit. Running these with the enable bit clear and then set separates masking from launching, and separates start from abort. It repeats identical writes to show that a no-change write is silent. It sets busy bits on several channels and then turns on all enables in one write, which shows that the shared-word launch path yields a multi-bit vector. A long pseudo-random stream of control, address, count and shared writes covers all channels and stray offsets. It compares every output against a model computed from the masks and edge rules.

// File: rtl/dma_lc_pkg.sv
package dma_lc_pkg;

   localparam logic [31:0] STD_WMASK  = 32'h7177_0703;
   localparam logic [31:0] SPEC_WMASK = 32'h5100_0002;
   localparam logic [31:0] SPEC_FORCE = 32'h0000_0002;

   typedef enum logic [1:0] {
      FLD_MADR = 2'd0,
      FLD_CNT  = 2'd1,
      FLD_CTRL = 2'd2,
      FLD_NONE = 2'd3
   } field_e;

   function automatic logic [31:0] ctrl_wmask(input bit absent, input bit special);
      if (absent)       return 32'h0;
      else if (special) return SPEC_WMASK;
      else              return STD_WMASK;
   endfunction

   function automatic logic [31:0] ctrl_force(input bit absent, input bit special);
      return (special && !absent) ? SPEC_FORCE : 32'h0;
   endfunction

endpackage

// File: rtl/dma_lc_decode.sv
module dma_lc_decode #(
   parameter int ADDR_W     = 12,
   parameter int NUM_CH     = 7,
   parameter int WIN_BASE   = 'h080,
   parameter int WIN_STRIDE = 16,
   parameter int SHARED_OFF = 'h0F0
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [NUM_CH-1:0] sel_madr,
   output logic [NUM_CH-1:0] sel_cnt,
   output logic [NUM_CH-1:0] sel_ctrl,
   output logic              sel_shared
);
   import dma_lc_pkg::*;

   localparam int LG_STRIDE = $clog2(WIN_STRIDE);
   localparam int WIN_IDX0  = WIN_BASE / WIN_STRIDE;

   logic [ADDR_W-LG_STRIDE-1:0] win_idx;
   logic [LG_STRIDE-1:0]        win_off;
   field_e                      fld;

   assign win_idx = wr_addr[ADDR_W-1:LG_STRIDE];
   assign win_off = wr_addr[LG_STRIDE-1:0];

   always_comb begin
      unique case (win_off)
         LG_STRIDE'('h0): fld = FLD_MADR;
         LG_STRIDE'('h4): fld = FLD_CNT;
         LG_STRIDE'('h8),
         LG_STRIDE'('hC): fld = FLD_CTRL;
         default:         fld = FLD_NONE;
      endcase
   end

   assign sel_shared = wr_en && (wr_addr == ADDR_W'(SHARED_OFF));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_win
      logic hit;
      assign hit         = wr_en && (win_idx == (ADDR_W-LG_STRIDE)'(WIN_IDX0 + n));
      assign sel_madr[n] = hit && (fld == FLD_MADR);
      assign sel_cnt[n]  = hit && (fld == FLD_CNT);
      assign sel_ctrl[n] = hit && (fld == FLD_CTRL);
   end
endmodule

// File: rtl/dma_lc_enable.sv
module dma_lc_enable #(
   parameter int DATA_W  = 32,
   parameter int NUM_CH  = 7,
   parameter int FIELD_W = 4,
   parameter int EN_POS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cfg_o,
   output logic [NUM_CH-1:0] en_vec,
   output logic [NUM_CH-1:0] rise_vec
);
   logic [DATA_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= '0;
      else if (we) cfg_q <= wdata;
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
      localparam int P = FIELD_W * n + EN_POS;
      assign en_vec[n]   = cfg_q[P];
      assign rise_vec[n] = we && wdata[P] && !cfg_q[P];
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/dma_lc_chan.sv
module dma_lc_chan #(
   parameter int              DATA_W    = 32,
   parameter int              START_BIT = 24,
   parameter bit              PRESENT   = 1'b1,
   parameter logic [DATA_W-1:0] WMASK   = '1,
   parameter logic [DATA_W-1:0] FORCE   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_madr,
   input  logic              we_cnt,
   input  logic              we_ctrl,
   input  logic [DATA_W-1:0] wdata,
   input  logic              en_bit,
   input  logic              en_rise,
   output logic [DATA_W-1:0] madr_o,
   output logic [DATA_W-1:0] cnt_o,
   output logic [DATA_W-1:0] ctrl_o,
   output logic              start_o,
   output logic              abort_o
);
   logic [DATA_W-1:0] madr_q, cnt_q, ctrl_q, masked;
   logic              start_q, abort_q, changed, busy_old, busy_new;

   assign masked   = (wdata & WMASK) | FORCE;
   assign changed  = we_ctrl && (masked != ctrl_q);
   assign busy_old = ctrl_q[START_BIT];
   assign busy_new = masked[START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         madr_q  <= '0;
         cnt_q   <= '0;
         ctrl_q  <= FORCE;
         start_q <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
         if (we_madr && PRESENT) madr_q <= wdata;
         if (we_cnt && PRESENT)  cnt_q  <= wdata;
         if (changed) begin
            ctrl_q <= masked;
            if (!busy_old && busy_new && en_bit) start_q <= 1'b1;
            if (busy_old && !busy_new)           abort_q <= 1'b1;
         end
         if (en_rise && busy_old) start_q <= 1'b1;
      end
   end

   assign madr_o  = madr_q;
   assign cnt_o   = cnt_q;
   assign ctrl_o  = ctrl_q;
   assign start_o = start_q;
   assign abort_o = abort_q;
endmodule

// File: rtl/dma_launch_ctrl.sv
module dma_launch_ctrl #(
   parameter int              ADDR_W      = 12,
   parameter int              DATA_W      = 32,
   parameter int              NUM_CH      = 7,
   parameter int              FIELD_W     = 4,
   parameter int              EN_POS      = 3,
   parameter int              START_BIT   = 24,
   parameter int              WIN_BASE    = 'h080,
   parameter int              WIN_STRIDE  = 16,
   parameter int              SHARED_OFF  = 'h0F0,
   parameter int              SPECIAL_CH  = 6,
   parameter logic [NUM_CH-1:0] ABSENT_MASK = 7'b010_0000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [NUM_CH-1:0]        start_vec,
   output logic [NUM_CH-1:0]        abort_vec,
   output logic [NUM_CH*DATA_W-1:0] chan_madr,
   output logic [NUM_CH*DATA_W-1:0] chan_cnt,
   output logic [NUM_CH*DATA_W-1:0] chan_ctrl,
   output logic [DATA_W-1:0]        prio_cfg
);
   import dma_lc_pkg::*;

   if (DATA_W != 32) begin : g_bad_width
      $error("dma_launch_ctrl: DATA_W must be 32 to match the control masks");
   end
   if (NUM_CH * FIELD_W > DATA_W || EN_POS >= FIELD_W) begin : g_bad_field
      $error("dma_launch_ctrl: enable fields do not fit the shared word");
   end
   if (START_BIT >= DATA_W || SPECIAL_CH >= NUM_CH) begin : g_bad_pos
      $error("dma_launch_ctrl: start bit or special channel out of range");
   end
   if (WIN_BASE + NUM_CH * WIN_STRIDE > (1 << ADDR_W) || WIN_STRIDE < 16) begin : g_bad_map
      $error("dma_launch_ctrl: channel windows exceed address space");
   end

   logic [NUM_CH-1:0] sel_madr, sel_cnt, sel_ctrl, en_vec, rise_vec;
   logic              sel_shared;

   dma_lc_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .WIN_BASE(WIN_BASE),
      .WIN_STRIDE(WIN_STRIDE), .SHARED_OFF(SHARED_OFF)
   ) dec_i (
      .wr_en(wr_en), .wr_addr(wr_addr), .sel_madr(sel_madr),
      .sel_cnt(sel_cnt), .sel_ctrl(sel_ctrl), .sel_shared(sel_shared)
   );

   dma_lc_enable #(
      .DATA_W(DATA_W), .NUM_CH(NUM_CH), .FIELD_W(FIELD_W), .EN_POS(EN_POS)
   ) en_i (
      .clk(clk), .rst_n(rst_n), .we(sel_shared), .wdata(wr_data),
      .cfg_o(prio_cfg), .en_vec(en_vec), .rise_vec(rise_vec)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam bit ABSENT  = ABSENT_MASK[n];
      localparam bit SPECIAL = (n == SPECIAL_CH);
      dma_lc_chan #(
         .DATA_W(DATA_W), .START_BIT(START_BIT), .PRESENT(!ABSENT),
         .WMASK(ctrl_wmask(ABSENT, SPECIAL)), .FORCE(ctrl_force(ABSENT, SPECIAL))
      ) ch_i (
         .clk(clk), .rst_n(rst_n),
         .we_madr(sel_madr[n]), .we_cnt(sel_cnt[n]), .we_ctrl(sel_ctrl[n]),
         .wdata(wr_data), .en_bit(en_vec[n]), .en_rise(rise_vec[n]),
         .madr_o(chan_madr[n*DATA_W +: DATA_W]),
         .cnt_o(chan_cnt[n*DATA_W +: DATA_W]),
         .ctrl_o(chan_ctrl[n*DATA_W +: DATA_W]),
         .start_o(start_vec[n]), .abort_o(abort_vec[n])
      );
   end
endmodule

// File: rtl/dma_lc_checker.sv
module dma_lc_checker #(
   parameter int              DATA_W      = 32,
   parameter int              NUM_CH      = 7,
   parameter int              FIELD_W     = 4,
   parameter int              EN_POS      = 3,
   parameter int              START_BIT   = 24,
   parameter int              SPECIAL_CH  = 6,
   parameter logic [NUM_CH-1:0] ABSENT_MASK = 7'b010_0000
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CH-1:0]        start_vec,
   input logic [NUM_CH-1:0]        abort_vec,
   input logic [NUM_CH*DATA_W-1:0] chan_ctrl,
   input logic [DATA_W-1:0]        prio_cfg
);
   import dma_lc_pkg::*;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_a
      logic [DATA_W-1:0] ctl;
      assign ctl = chan_ctrl[n*DATA_W +: DATA_W];

      AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         start_vec[n] |-> ctl[START_BIT]);                           // R4
      AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
         start_vec[n] |-> prio_cfg[FIELD_W*n+EN_POS]);               // R7
      AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         abort_vec[n] |-> !ctl[START_BIT]);                          // R5
      AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         start_vec[n] |=> !start_vec[n]);                            // R10
      AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         abort_vec[n] |=> !abort_vec[n]);                            // R10
      AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         !(start_vec[n] && abort_vec[n]));                           // R10

      if (ABSENT_MASK[n]) begin : g_absent
         AST_ABSENT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !start_vec[n] && !abort_vec[n] && ctl == '0);            // R9
      end else if (n == SPECIAL_CH) begin : g_special
         AST_SPECIAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            ((ctl & ~SPEC_WMASK) == '0) && ctl[1]);                  // R3
      end else begin : g_std
         AST_STD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl & ~STD_WMASK) == '0);                               // R2
      end
   end
endmodule

bind dma_launch_ctrl dma_lc_checker #(
   .DATA_W(DATA_W), .NUM_CH(NUM_CH), .FIELD_W(FIELD_W), .EN_POS(EN_POS),
   .START_BIT(START_BIT), .SPECIAL_CH(SPECIAL_CH), .ABSENT_MASK(ABSENT_MASK)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start_vec(start_vec), .abort_vec(abort_vec),
   .chan_ctrl(chan_ctrl), .prio_cfg(prio_cfg)
);

// File: tb/dma_launch_ctrl_tb_top.sv
module dma_launch_ctrl_tb_top;
   localparam int NCH = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [11:0]       wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [NCH-1:0]    start_vec, abort_vec;
   logic [NCH*32-1:0] chan_madr, chan_cnt, chan_ctrl;
   logic [31:0]       prio_cfg;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_ctrl [NCH];
   logic [31:0] m_madr [NCH];
   logic [31:0] m_cnt  [NCH];
   logic [31:0] m_cfg;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   always #2 clk = ~clk;

   dma_launch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start_vec(start_vec), .abort_vec(abort_vec),
      .chan_madr(chan_madr), .chan_cnt(chan_cnt), .chan_ctrl(chan_ctrl),
      .prio_cfg(prio_cfg)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [NCH*32-1:0] act, input logic [NCH*32-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [NCH*32-1:0] pack(input logic [31:0] a [NCH]);
      logic [NCH*32-1:0] r;
      for (int n = 0; n < NCH; n++) r[n*32 +: 32] = a[n];
      return r;
   endfunction

   task automatic compare_state(input string req, input logic [NCH-1:0] es,
                                input logic [NCH-1:0] ea);
      check(start_vec == es, req, "start_vec", NCH*32'(start_vec), NCH*32'(es));
      check(abort_vec == ea, req, "abort_vec", NCH*32'(abort_vec), NCH*32'(ea));
      check(chan_ctrl == pack(m_ctrl), req, "chan_ctrl", chan_ctrl, pack(m_ctrl));
      check(chan_madr == pack(m_madr), req, "chan_madr", chan_madr, pack(m_madr));
      check(chan_cnt == pack(m_cnt), req, "chan_cnt", chan_cnt, pack(m_cnt));
      check(prio_cfg == m_cfg, req, "prio_cfg", NCH*32'(prio_cfg), NCH*32'(m_cfg));
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input string req);
      logic [NCH-1:0] es = '0, ea = '0;
      int idx = int'(a[11:4]);
      if (a == 12'h0F0) begin
         for (int n = 0; n < NCH; n++)
            if (n != 5 && d[4*n+3] && !m_cfg[4*n+3] && m_ctrl[n][24]) es[n] = 1'b1;
         m_cfg = d;
      end else if (idx >= 8 && idx <= 14 && idx != 13) begin
         int n = idx - 8;
         case (a[3:0])
            4'h0: m_madr[n] = d;
            4'h4: m_cnt[n] = d;
            4'h8, 4'hC: begin
               logic [31:0] mk = (n == 6) ? ((d & 32'h5100_0002) | 32'h2)
                                          : (d & 32'h7177_0703);
               if (mk != m_ctrl[n]) begin
                  if (!m_ctrl[n][24] && mk[24] && m_cfg[4*n+3]) es[n] = 1'b1;
                  if (m_ctrl[n][24] && !mk[24]) ea[n] = 1'b1;
                  m_ctrl[n] = mk;
               end
            end
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      compare_state(req, es, ea);
      @(posedge clk); #1;
      compare_state("R10", '0, '0);
   endtask

   function automatic logic [11:0] ctl_off(input int n);
      return 12'(12'h088 + 16 * n);
   endfunction

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int n = 0; n < NCH; n++) begin
         m_ctrl[n] = (n == 6) ? 32'h2 : 32'h0;
         m_madr[n] = '0;
         m_cnt[n]  = '0;
      end
      m_cfg = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      compare_state("R1", '0, '0);

      // per-channel sweep: masks, no-enable, start, repeat, abort
      for (int n = 0; n < NCH; n++) begin
         do_wr(ctl_off(n), 32'hFFFF_FFFF, (n == 6) ? "R3" : (n == 5) ? "R9" : "R2");
         do_wr(ctl_off(n), 32'hFFFF_FFFF, "R6");
         do_wr(ctl_off(n), 32'h0, "R5");
         do_wr(12'h0F0, 32'h1 << (4 * n + 3), "R7");
         do_wr(ctl_off(n) + 12'h4, 32'h0100_0000, "R4");
         do_wr(ctl_off(n), 32'h0100_0000, "R6");
         do_wr(ctl_off(n), 32'h8000_0000, "R5");
         do_wr(ctl_off(n) - 12'h8, 32'hA5A5_0000 + 32'(n), "R8");
         do_wr(ctl_off(n) - 12'h4, 32'h0000_5A00 + 32'(n), "R8");
         do_wr(12'h0F0, 32'h0, "R7");
      end

      // launch from the shared word, several channels at once
      for (int n = 0; n < NCH; n++) do_wr(ctl_off(n), 32'h0100_0000, "R4");
      do_wr(12'h0F0, 32'h0888_8888, "R7");
      do_wr(12'h0F0, 32'h0888_8888, "R7");
      do_wr(12'h0F0, 32'h0800_0008, "R7");
      do_wr(12'h0F0, 32'hFFFF_FFFF, "R7");
      for (int n = 0; n < NCH; n++) do_wr(ctl_off(n), 32'h0, "R5");

      // stray offsets
      do_wr(12'h100, 32'hFFFF_FFFF, "R10");
      do_wr(12'h0F4, 32'hFFFF_FFFF, "R10");
      do_wr(12'h07C, 32'hFFFF_FFFF, "R10");
      do_wr(12'h0D8, 32'h0100_0000, "R9");
      do_wr(12'h0D0, 32'h1234_5678, "R9");

      // pseudo-random stream
      for (int i = 0; i < 1500; i++) begin
         logic [11:0] a;
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         case (lfsr[2:0])
            3'd0:    a = 12'h0F0;
            3'd1:    a = 12'(12'h080 + 16 * (lfsr[10:8] % 7)) + 12'(4 * lfsr[12:11]);
            3'd2:    a = {4'h0, lfsr[15:8]};
            default: a = ctl_off(int'(lfsr[10:8]) % 7) + (lfsr[11] ? 12'h4 : 12'h0);
         endcase
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         do_wr(a, lfsr[3] ? (lfsr & 32'h0900_0000) | {28'h0, lfsr[7:4]} : lfsr,
               "R7 R4 R5 R2");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule